// File: doc/BRIEF.md
# Sectored Cache Tag and Line-State Directory

This block keeps the tags and coherence states for a 32 KB, two-way set-associative writeback data cache. Storage is grouped into 64-byte sectors. Each sector has one tag, and that tag covers two 32-byte lines. Each line has its own MESI state. Because of this, a lookup can match the tag of a sector while the addressed line is still Invalid. The directory reports that case as a sector hit with a line miss. The cache controller then fetches only the missing 32-byte line and reuses the sector that is already in place.

A request is one address and one operation code, presented for one cycle. The lookup results (sector hit, line hit, hit way and line state) are combinational and show the directory contents before the request takes effect. The same is true of the indications that come with each operation: the upgrade request, the snoop writeback flag and the victim report. Any state change the request causes is written at the next rising clock edge. When a fill misses the sector, the directory replaces the least-recently-used way of the set. In the same cycle it lists every Modified line of the evicted sector, so that those lines can be written back.

Top module: `sect_tag_dir`

## Requirements
- R1: The address is split into offset bits [4:0], a line-select bit [5], set index bits [13:6] and tag bits [31:14]. A request reports sector_hit=1 when a valid sector in the indexed set holds that tag. The full 18-bit tag must match.
- R2: Line states are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3. If the tag matches but the selected line is Invalid, the block reports sector_hit=1, line_hit=0 and line_state=0.
- R3: A fill (req_op=1) that hits the sector writes only the selected line. The new state is Exclusive when fill_excl=1 and Shared when fill_excl=0. The tag and the other line's state are kept.
- R4: A fill that misses the sector replaces the way named by the set's LRU bit and stores the new tag. The other line of the new sector becomes Invalid, and the selected line takes the fill state.
- R5: During a sector-miss fill, victim_mask bit k is 1 when line k of the replaced sector is Modified. victim_valid is 1 when any mask bit is set, and victim_addr = {old tag, set, 6'b0}. When victim_valid is 0, all three victim outputs are 0.
- R6: A write (req_op=2) that hits an Exclusive line changes it to Modified, and a write hit on a Modified line leaves it Modified. A write hit on a Shared line asserts upgrade_req and leaves the line Shared.
- R7: An upgrade acknowledge (req_op=3) that hits a Shared line changes it to Modified. An acknowledge that hits a line in any other state leaves that state unchanged.
- R8: A snoop read (req_op=4) changes a Modified or Exclusive line to Shared and leaves a Shared line Shared. snoop_wb is asserted only when the line was Modified.
- R9: A snoop invalidate (req_op=5) makes a valid line Invalid and asserts snoop_wb when the line was Modified. The tag and the other line are kept, so the sector still hits.
- R10: Each set has one LRU bit that names the way to replace next. A fill, or a lookup (req_op=0), write or acknowledge that hits a line, marks the accessed way as most recent. Snoops and line misses leave the LRU bit unchanged.
- R11: After reset, no sector is valid and every LRU bit selects way 0.
- R12: When req_valid=0, every output is 0 and no state changes. Operation codes 6 and 7 report lookup results but change nothing.
- R13: At most one way hits for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 lookup, 1 fill, 2 write, 3 upgrade ack, 4 snoop read, 5 snoop invalidate |
| req_addr | input | 32 | Request byte address |
| fill_excl | input | 1 | Fill state: 1 Exclusive, 0 Shared |
| sector_hit | output | 1 | Tag matched a valid sector |
| line_hit | output | 1 | Selected line is not Invalid |
| hit_way | output | 1 | Way that matched |
| line_state | output | 2 | State of the selected line |
| upgrade_req | output | 1 | Write hit on a Shared line needs a bus invalidate |
| snoop_wb | output | 1 | Snoop hit a Modified line |
| victim_valid | output | 1 | Replaced sector holds Modified data |
| victim_mask | output | 2 | Modified lines of the replaced sector |
| victim_addr | output | 32 | Base address of the replaced sector |

## Verification
The directed sequences run on a single set and follow the life of one sector. The sector is allocated, then its second line is filled while the tag is shared. After that it is written, upgraded, snooped and finally evicted while dirty. These steps tell a sector hit apart from a line hit, check each MESI edge one at a time, and check that the victim mask names exactly the dirty lines. A random phase draws operations over a small pool of tags and sets, so ways conflict often. In that phase, LRU choice, double-tag cases and the ignored operation codes are compared against a behavioural model on every cycle.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [2:0] {
    OP_LOOK    = 3'd0,
    OP_FILL    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_UPG_ACK = 3'd3,
    OP_SNP_RD  = 3'd4,
    OP_SNP_INV = 3'd5,
    OP_NOP6    = 3'd6,
    OP_NOP7    = 3'd7
  } op_e;

  // Next line state for an operation that targets the selected line
  function automatic mesi_e mesi_next(op_e op, mesi_e cur, logic excl);
    case (op)
      OP_FILL:    return excl ? ST_E : ST_S;
      OP_WRITE:   return (cur == ST_E) ? ST_M : cur;
      OP_UPG_ACK: return (cur == ST_S) ? ST_M : cur;
      OP_SNP_RD:  return (cur == ST_M || cur == ST_E) ? ST_S : cur;
      OP_SNP_INV: return ST_I;
      default:    return cur;
    endcase
  endfunction

  // Whether an operation counts as a use of the way for replacement order
  function automatic logic lru_touches(op_e op, logic line_hit);
    return (op == OP_FILL) ||
           (line_hit && (op == OP_LOOK || op == OP_WRITE || op == OP_UPG_ACK));
  endfunction

endpackage

// File: rtl/sdir_way.sv
module sdir_way
  import sdir_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int SET_W = $clog2(SETS),
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_line,
  output logic             hit_o,
  output logic [1:0]       line_st_o,
  output logic [1:0]       st0_o,
  output logic [1:0]       st1_o,
  output logic [TAG_W-1:0] tag_o,
  input  logic             wr_en,
  input  logic             wr_alloc,
  input  logic [SET_W-1:0] wr_set,
  input  logic             wr_line,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [1:0]       wr_state
);

  logic [TAG_W-1:0] tag_q [SETS];
  logic             vld_q [SETS];
  logic [1:0]       st_q  [SETS][2];

  assign hit_o     = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
  assign line_st_o = st_q[rd_set][rd_line];
  assign st0_o     = st_q[rd_set][0];
  assign st1_o     = st_q[rd_set][1];
  assign tag_o     = tag_q[rd_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]    <= '0;
        vld_q[s]    <= 1'b0;
        st_q[s][0]  <= ST_I;
        st_q[s][1]  <= ST_I;
      end
    end else if (wr_en) begin
      if (wr_alloc) begin
        tag_q[wr_set]           <= wr_tag;
        vld_q[wr_set]           <= 1'b1;
        st_q[wr_set][~wr_line]  <= ST_I;
      end
      st_q[wr_set][wr_line] <= wr_state;
    end
  end

  // Checker state: remembers the last write to compare the array afterwards
  logic             chk_vld_q, chk_alloc_q, chk_line_q;
  logic [SET_W-1:0] chk_set_q;
  logic [TAG_W-1:0] chk_tag_q, chk_oldtag_q;
  logic [1:0]       chk_sib_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld_q    <= 1'b0;
      chk_alloc_q  <= 1'b0;
      chk_line_q   <= 1'b0;
      chk_set_q    <= '0;
      chk_tag_q    <= '0;
      chk_oldtag_q <= '0;
      chk_sib_q    <= ST_I;
    end else begin
      chk_vld_q    <= wr_en;
      chk_alloc_q  <= wr_alloc;
      chk_line_q   <= wr_line;
      chk_set_q    <= wr_set;
      chk_tag_q    <= wr_tag;
      chk_oldtag_q <= tag_q[wr_set];
      chk_sib_q    <= st_q[wr_set][~wr_line];
    end
  end

  p_alloc_sibling_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld_q && chk_alloc_q) |-> (st_q[chk_set_q][~chk_line_q] == ST_I &&
                                    tag_q[chk_set_q] == chk_tag_q && vld_q[chk_set_q]));

  p_line_fill_keeps_sector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld_q && !chk_alloc_q) |-> (tag_q[chk_set_q] == chk_oldtag_q &&
                                     st_q[chk_set_q][~chk_line_q] == chk_sib_q));

endmodule

// File: rtl/sdir_lru.sv
module sdir_lru #(
  parameter int SETS  = 256,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  output logic             victim_o,
  input  logic             touch,
  input  logic             touch_way
);

  logic lru_q [SETS];

  assign victim_o = lru_q[set_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
    end else if (touch) begin
      lru_q[set_i] <= ~touch_way;
    end
  end

  logic             chk_touch_q, chk_way_q;
  logic [SET_W-1:0] chk_set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_touch_q <= 1'b0;
      chk_way_q   <= 1'b0;
      chk_set_q   <= '0;
    end else begin
      chk_touch_q <= touch;
      chk_way_q   <= touch_way;
      chk_set_q   <= set_i;
    end
  end

  p_lru_points_away_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_touch_q |-> (lru_q[chk_set_q] != chk_way_q));

endmodule

// File: rtl/sect_tag_dir.sv
module sect_tag_dir
  import sdir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fill_excl,
  output logic              sector_hit,
  output logic              line_hit,
  output logic              hit_way,
  output logic [1:0]        line_state,
  output logic              upgrade_req,
  output logic              snoop_wb,
  output logic              victim_valid,
  output logic [1:0]        victim_mask,
  output logic [ADDR_W-1:0] victim_addr
);

  localparam int WAYS    = 2;
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int SET_W   = $clog2(SETS);
  localparam int SET_LSB = OFF_W + 1;
  localparam int TAG_LSB = SET_LSB + SET_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  // Address fields
  logic [SET_W-1:0] set_w;
  logic [TAG_W-1:0] tag_w;
  logic             line_w;
  logic             unused_off;
  assign set_w      = req_addr[TAG_LSB-1:SET_LSB];
  assign tag_w      = req_addr[ADDR_W-1:TAG_LSB];
  assign line_w     = req_addr[OFF_W];
  assign unused_off = ^req_addr[OFF_W-1:0];

  // Per-way views
  logic [WAYS-1:0]  hit_w;
  logic [1:0]       lst_w  [WAYS];
  logic [1:0]       st0_w  [WAYS];
  logic [1:0]       st1_w  [WAYS];
  logic [TAG_W-1:0] vtag_w [WAYS];
  logic [WAYS-1:0]  wr_en_w;

  // Internal events, named for the checks
  op_e        op_w;
  logic       any_hit, hit_idx, cur_line_hit;
  mesi_e      cur_st, new_st;
  logic       fill_ev, alloc_ev, state_ev, upd_ev, touch_ev;
  logic       lru_victim, tgt_way;

  sdir_lru #(.SETS(SETS), .SET_W(SET_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_w),
    .victim_o  (lru_victim),
    .touch     (touch_ev),
    .touch_way (tgt_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sdir_way #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (set_w),
      .rd_tag    (tag_w),
      .rd_line   (line_w),
      .hit_o     (hit_w[w]),
      .line_st_o (lst_w[w]),
      .st0_o     (st0_w[w]),
      .st1_o     (st1_w[w]),
      .tag_o     (vtag_w[w]),
      .wr_en     (wr_en_w[w]),
      .wr_alloc  (alloc_ev),
      .wr_set    (set_w),
      .wr_line   (line_w),
      .wr_tag    (tag_w),
      .wr_state  (new_st)
    );
    assign wr_en_w[w] = upd_ev && (tgt_way == w[0]);
  end

  assign op_w         = op_e'(req_op);
  assign any_hit      = |hit_w;
  assign hit_idx      = hit_w[1];
  assign cur_st       = any_hit ? mesi_e'(lst_w[hit_idx]) : ST_I;
  assign cur_line_hit = (cur_st != ST_I);

  assign fill_ev  = req_valid && (op_w == OP_FILL);
  assign alloc_ev = fill_ev && !any_hit;
  assign state_ev = req_valid && cur_line_hit &&
                    (op_w == OP_WRITE || op_w == OP_UPG_ACK ||
                     op_w == OP_SNP_RD || op_w == OP_SNP_INV);
  assign upd_ev   = fill_ev || state_ev;
  assign tgt_way  = alloc_ev ? lru_victim : hit_idx;
  assign new_st   = mesi_next(op_w, cur_st, fill_excl);
  assign touch_ev = req_valid && lru_touches(op_w, cur_line_hit);

  // Lookup results
  assign sector_hit = req_valid && any_hit;
  assign line_hit   = req_valid && cur_line_hit;
  assign hit_way    = req_valid && any_hit && hit_idx;
  assign line_state = req_valid ? cur_st : ST_I;

  // Side indications
  assign upgrade_req = req_valid && (op_w == OP_WRITE) && (cur_st == ST_S);
  assign snoop_wb    = req_valid && (op_w == OP_SNP_RD || op_w == OP_SNP_INV) &&
                       (cur_st == ST_M);

  assign victim_mask  = alloc_ev ? {st1_w[lru_victim] == ST_M, st0_w[lru_victim] == ST_M}
                                 : 2'b00;
  assign victim_valid = |victim_mask;
  assign victim_addr  = victim_valid ? {vtag_w[lru_victim], set_w, {SET_LSB{1'b0}}}
                                     : '0;

  p_single_way_hit_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_w));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (wr_en_w == '0 && !touch_ev && !victim_valid && !snoop_wb));

endmodule

// File: tb/sect_tag_dir_tb_top.sv
module sect_tag_dir_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [31:0] req_addr;
  logic        fill_excl;
  logic        sector_hit, line_hit, hit_way, upgrade_req, snoop_wb, victim_valid;
  logic [1:0]  line_state, victim_mask;
  logic [31:0] victim_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sect_tag_dir dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .fill_excl(fill_excl), .sector_hit(sector_hit),
    .line_hit(line_hit), .hit_way(hit_way), .line_state(line_state),
    .upgrade_req(upgrade_req), .snoop_wb(snoop_wb), .victim_valid(victim_valid),
    .victim_mask(victim_mask), .victim_addr(victim_addr)
  );

  // Behavioural reference model
  bit [17:0] m_tag [256][2];
  bit        m_val [256][2];
  int        m_st  [256][2][2];
  bit        m_lru [256];

  function automatic void model_reset();
    for (int s = 0; s < 256; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin
        m_tag[s][w] = 0; m_val[s][w] = 0; m_st[s][w][0] = 0; m_st[s][w][1] = 0;
      end
    end
  endfunction

  task automatic compare(input string rq, input bit [10:0] got, input bit [10:0] exp,
                         input bit [31:0] gva, input bit [31:0] eva);
    checks++;
    if (got !== exp || gva !== eva) begin
      fails++;
      $display("FAIL %s: outputs got=%b exp=%b victim_addr got=%h exp=%h",
               rq, got, exp, gva, eva);
    end
  endtask

  task automatic req(input int op, input bit [31:0] a, input bit ex, input string rq);
    int s, ln, hw, st, v;
    bit [17:0] tg;
    bit sh, lh, upg, wb, vv;
    bit [1:0] vm;
    bit [31:0] va;
    @(negedge clk);
    req_valid = 1; req_op = op[2:0]; req_addr = a; fill_excl = ex;
    #1;
    s = a[13:6]; ln = a[5]; tg = a[31:14];
    hw = -1;
    for (int w = 0; w < 2; w++) if (m_val[s][w] && m_tag[s][w] == tg) hw = w;
    sh = (hw >= 0);
    st = sh ? m_st[s][hw][ln] : 0;
    lh = (st != 0);
    upg = (op == 2) && (st == 1);
    wb  = (op == 4 || op == 5) && (st == 3);
    vm = 0; va = 0;
    if (op == 1 && !sh) begin
      v = m_lru[s];
      vm[0] = (m_st[s][v][0] == 3);
      vm[1] = (m_st[s][v][1] == 3);
      if (vm != 0) va = {m_tag[s][v], s[7:0], 6'b0};
    end
    vv = (vm != 0);
    compare(rq, {sector_hit, line_hit, hit_way, line_state, upgrade_req, snoop_wb,
                 victim_valid, victim_mask},
                {sh, lh, (hw == 1), st[1:0], upg, wb, vv, vm}, victim_addr, va);
    @(posedge clk);
    if (op == 1) begin
      v = sh ? hw : int'(m_lru[s]);
      if (!sh) begin
        m_tag[s][v] = tg; m_val[s][v] = 1; m_st[s][v][1-ln] = 0;
      end
      m_st[s][v][ln] = ex ? 2 : 1;
      m_lru[s] = (v == 0);
    end else if (lh) begin
      case (op)
        0: m_lru[s] = (hw == 0);
        2: begin if (st == 2) m_st[s][hw][ln] = 3; m_lru[s] = (hw == 0); end
        3: begin if (st == 1) m_st[s][hw][ln] = 3; m_lru[s] = (hw == 0); end
        4: if (st >= 2) m_st[s][hw][ln] = 1;
        5: m_st[s][hw][ln] = 0;
        default: ;
      endcase
    end
  endtask

  task automatic idle(input bit [2:0] op, input bit [31:0] a);
    @(negedge clk);
    req_valid = 0; req_op = op; req_addr = a; fill_excl = 1;
    #1;
    // R12: no request means every output stays low
    compare("R12", {sector_hit, line_hit, hit_way, line_state, upgrade_req, snoop_wb,
                    victim_valid, victim_mask}, 11'b0, victim_addr, 32'b0);
    @(posedge clk);
  endtask

  localparam bit [31:0] A  = 32'h0000_4040;  // tag 1, set 1, line 0
  localparam bit [31:0] A1 = 32'h0000_4060;  // same sector, line 1
  localparam bit [31:0] B  = 32'h0000_8040;  // tag 2, set 1
  localparam bit [31:0] C  = 32'h0000_C040;  // tag 3, set 1
  localparam bit [31:0] H  = 32'hFFFF_C7E0;  // tag all ones, set 31, line 1

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; fill_excl = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    req(0, A, 0, "R11");
    req(0, H, 0, "R11");
    req(1, A, 1, "R4");            // allocates way 0, Exclusive
    req(0, A, 0, "R1");
    req(0, A1, 0, "R2");           // tag hit, line miss
    req(0, A ^ 32'h0002_0000, 0, "R1");  // one tag bit differs
    req(1, A1, 0, "R3");           // line fill into existing sector, Shared
    req(0, A, 0, "R3");
    req(0, A1, 0, "R3");
    req(2, A, 0, "R6");            // E -> M
    req(2, A, 0, "R6");            // M stays
    req(2, A1, 0, "R6");           // Shared: upgrade request
    req(0, A1, 0, "R6");
    req(3, A1, 0, "R7");           // S -> M
    req(3, A1, 0, "R7");           // ack on M: no change
    req(1, B, 0, "R10");           // LRU selects way 1
    req(0, B, 0, "R10");
    req(1, C, 1, "R5");            // evicts way 0 with both lines dirty
    req(0, A, 0, "R4");
    req(0, C + 32'h20, 0, "R4");   // sibling of new sector is Invalid
    req(2, C, 0, "R6");
    req(4, C, 0, "R8");            // M -> S with writeback flag
    req(4, C, 0, "R8");            // S stays
    req(1, C + 32'h20, 1, "R3");
    req(4, C + 32'h20, 0, "R8");   // E -> S, no flag
    req(2, C + 32'h20, 0, "R6");
    req(3, C + 32'h20, 0, "R7");
    req(5, C + 32'h20, 0, "R9");   // M -> I with flag
    req(0, C, 0, "R9");            // sector still hits
    req(5, C, 0, "R9");
    req(0, C, 0, "R9");
    req(4, B, 0, "R10");           // snoop does not touch LRU
    req(1, A, 0, "R10");
    req(6, B, 1, "R12");
    req(7, A, 1, "R12");
    idle(3'd1, 32'h0000_0040);
    idle(3'd2, A);
    req(0, A, 0, "R12");
    req(1, H, 1, "R1");
    req(0, H, 0, "R1");
    req(0, H & 32'hFFFF_FFDF, 0, "R2");

    // Random phase with heavy set conflicts
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] a;
      int sel;
      sel = $urandom_range(0, 2);
      a = {14'($urandom_range(1, 4)) | ((sel == 2) ? 14'h3FF0 : 14'h0),
           4'($urandom_range(0, 1)),
           (sel == 0) ? 8'd0 : ((sel == 1) ? 8'd1 : 8'd255),
           1'($urandom_range(0, 1)), 5'($urandom_range(0, 31))};
      if ($urandom_range(0, 15) == 0) idle(3'($urandom_range(0, 7)), a);
      else req($urandom_range(0, 7), a, 1'($urandom_range(0, 1)), "R13");
    end

    @(negedge clk); req_valid = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule